// File: doc/BRIEF.md
# SPI NOR flash command sequencer

This block sits on the master side of a serial NOR flash link. A host hands it one request at a time: a read, a 512-byte block write, a 4 KiB sector erase or a whole-chip erase. The block expands each request into the chip-select frames and bytes the flash expects, and passes them one byte at a time to a separate byte-level SPI engine. That engine shifts 8-bit transfers in mode 0 and returns the byte clocked in during each transfer.

Every request begins by polling the flash status until the device reports not-busy. While it keeps reporting busy, the bus is released for a programmable idle gap between polls. Commands that modify the array are each preceded by a write-enable frame. A block write becomes two page programs on consecutive pages, and each page program gets its own poll and write-enable. Write data arrives on a valid/ready byte stream. Read data leaves on a second valid/ready byte stream. Completion is a one-cycle pulse that carries an error flag taken from the program/erase-fail status bit.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and in the cycle after it, chip select is high (`cs_n`=1), `req_ready` is 1, and `xfer_req` and `done` are 0.
- R2: Every request starts with a status frame of its own. The frame is exactly two bytes, 0x05 then the filler 0xA5, and the byte returned for the filler is the status. Chip select goes high after each status frame.
- R3: Status frames repeat while status bit 0 (busy) is 1. After a busy status, chip select stays high for at least POLL_GAP+1 cycles. Between any two frames it stays high for at least CS_GAP+1 cycles.
- R4: Page program, sector erase and chip erase are each immediately preceded by a one-byte frame 0x06, sent after the final not-busy status frame. A read has no such frame.
- R5: A read (`req_op`=0) sends one frame: 0x03, then `req_addr` as three bytes with the most significant byte first, then `req_len` filler bytes 0xA5. A length of 0 sends only the four header bytes. Each byte returned during a filler goes out on `rd_data`, in order, and is held stable with `rd_valid` high until `rd_ready`.
- R6: A block write (`req_op`=1) treats `req_addr` as block number n. It issues two page programs: one at byte address (2n)·256 and one at (2n+1)·256. Each frame is 0x02, the three address bytes, then exactly 256 bytes taken in order from the write stream. Each page program has its own status polling and write-enable.
- R7: A sector erase (`req_op`=2) treats `req_addr` as sector number s and sends 0x20 followed by the three bytes of s·4096, with no data.
- R8: A chip erase (`req_op`=3) sends the single byte 0xC7 in its own frame.
- R9: `err` at `done` is 1 exactly when some not-busy status seen during that request had bit 5 set. Bit 5 in a busy status is ignored, and every new request starts with the flag clear.
- R10: `done` is a single-cycle pulse in the first idle cycle after the last frame's gap. `req_ready` is 1 only while idle, which is never inside a request.
- R11: `xfer_req` is high only while chip select is low. It stays high with a stable `xfer_tx` until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 read, 1 block write, 2 sector erase, 3 chip erase |
| req_addr | input | 24 | Byte address, block number or sector number |
| req_len | input | LEN_W | Read byte count |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Program/erase error flag, valid with done |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request to SPI engine |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Engine finished the transfer |
| xfer_rx | input | 8 | Byte shifted in |

## Verification
The bench builds the sequencer with CS_GAP=1 and POLL_GAP=6. With these values the two kinds of deselect gap have different lengths, so a busy retry that used the short gap is caught. They also keep a full busy-poll loop only a few dozen cycles long. PAGE_BYTES keeps its default of 256, so the block-write test runs both complete page programs against the write stream. LEN_W stays at 16, which lets reads of zero, one and several bytes, including one whose address wraps at the top of the 24-bit space, be tried next to each other.

// File: rtl/nor_seq_pkg.sv
// Shared codes and state types for the NOR flash command sequencer.
// Assumes a flash with the common single-byte opcode set and 3-byte addressing.
package nor_seq_pkg;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_SECER  = 8'h20;
    localparam logic [7:0] OPC_CHIPER = 8'hC7;
    localparam logic [7:0] FILLER     = 8'hA5;
    localparam int ST_BUSY = 0;
    localparam int ST_FAIL = 5;

    typedef enum logic [1:0] {
        OP_READ     = 2'd0,
        OP_BLKWR    = 2'd1,
        OP_SECERASE = 2'd2,
        OP_CHIPER   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_POLL = 2'd0,
        PH_WREN = 2'd1,
        PH_CMD  = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_XFER   = 3'd1,
        S_WAITWR = 3'd2,
        S_RDOUT  = 3'd3,
        S_GAP    = 3'd4
    } seq_state_e;
endpackage

// File: rtl/nor_frame_byte.sv
// Frame content generator: given the frame phase, the request kind and the
// byte index inside the current chip-select frame, it returns the byte to
// send, whether it is the frame's last byte and whether it is a data byte.
// Assumes idx never exceeds the frame length; purely combinational.
module nor_frame_byte
    import nor_seq_pkg::*;
#(
    parameter int IDX_W      = 18,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  phase_e             phase,
    input  op_e                op,
    input  logic [IDX_W-1:0]   idx,
    input  logic [23:0]        baddr,
    input  logic [LEN_W-1:0]   len,
    input  logic [7:0]         wbuf,
    output logic [7:0]         tx,
    output logic               last,
    output logic               is_data
);
    localparam logic [IDX_W-1:0] HDR = IDX_W'(4);

    logic [IDX_W-1:0] total;

    // Frame length in bytes for the current phase and request.
    always_comb begin
        unique case (phase)
            PH_POLL: total = IDX_W'(2);
            PH_WREN: total = IDX_W'(1);
            default: begin
                unique case (op)
                    OP_READ:     total = HDR + IDX_W'(len);
                    OP_BLKWR:    total = HDR + IDX_W'(PAGE_BYTES);
                    OP_SECERASE: total = HDR;
                    default:     total = IDX_W'(1);
                endcase
            end
        endcase
    end

    assign last    = (idx == total - IDX_W'(1));
    assign is_data = (phase == PH_CMD) && (idx >= HDR);

    // Byte selection: opcode, address bytes high first, then payload.
    always_comb begin
        tx = FILLER;
        unique case (phase)
            PH_POLL: tx = (idx == '0) ? OPC_STATUS : FILLER;
            PH_WREN: tx = OPC_WREN;
            default: begin
                if (idx == '0) begin
                    unique case (op)
                        OP_READ:     tx = OPC_READ;
                        OP_BLKWR:    tx = OPC_PROG;
                        OP_SECERASE: tx = OPC_SECER;
                        default:     tx = OPC_CHIPER;
                    endcase
                end else if (idx == IDX_W'(1)) begin
                    tx = baddr[23:16];
                end else if (idx == IDX_W'(2)) begin
                    tx = baddr[15:8];
                end else if (idx == IDX_W'(3)) begin
                    tx = baddr[7:0];
                end else begin
                    tx = (op == OP_READ) ? FILLER : wbuf;
                end
            end
        endcase
    end
endmodule

// File: rtl/nor_gap_timer.sv
// Deselect gap counter: loads a cycle count when a frame closes and reports
// expiry once it has counted down to zero. Assumes load is a single-cycle
// strobe issued on the last cycle of a frame.
module nor_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on strobe, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= value;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nor_cmd_seq.sv
// NOR flash command sequencer top. Accepts one host request at a time and
// runs it as a series of chip-select frames: status polls until not-busy,
// write-enable for modifying commands, then the command frame. A block write
// runs this twice, once per page. Assumes the attached SPI engine performs
// one 8-bit mode-0 transfer per xfer_req/xfer_done handshake.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_BYTES = 4096,
    parameter int CS_GAP       = 1,
    parameter int POLL_GAP     = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             done,
    output logic             err,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             cs_n,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx
);
    localparam int PG_SH  = $clog2(PAGE_BYTES);
    localparam int SEC_SH = $clog2(SECTOR_BYTES);
    localparam int IDX_W  = ((LEN_W > PG_SH) ? LEN_W : PG_SH) + 2;
    localparam int GAP_MX = (POLL_GAP > CS_GAP) ? POLL_GAP : CS_GAP;
    localparam int GAP_W  = $clog2(GAP_MX + 1);

    seq_state_e       state;
    phase_e           phase;
    op_e              op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic             half_q;
    logic [IDX_W-1:0] idx;
    logic [7:0]       wbuf;
    logic [7:0]       rbuf;
    logic             st_busy;
    logic             st_fail;
    logic             err_acc;
    logic             done_q;
    logic             err_q;
    logic [23:0]      baddr;
    logic [7:0]       tx;
    logic             last;
    logic             is_data;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_exp;

    // Byte address carried by the command frame for each request kind.
    always_comb begin
        unique case (op_q)
            OP_BLKWR:    baddr = 24'({addr_q[22:0], half_q} << PG_SH);
            OP_SECERASE: baddr = 24'(addr_q << SEC_SH);
            default:     baddr = addr_q;
        endcase
    end

    nor_frame_byte #(
        .IDX_W(IDX_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_frame (
        .phase(phase), .op(op_q), .idx(idx), .baddr(baddr), .len(len_q),
        .wbuf(wbuf), .tx(tx), .last(last), .is_data(is_data)
    );

    // Frame close strobe and the gap it needs (long after a busy status).
    always_comb begin
        gap_load = 1'b0;
        gap_val  = GAP_W'(CS_GAP);
        if (state == S_XFER && xfer_done && last && !(is_data && op_q == OP_READ)) begin
            gap_load = 1'b1;
            if (phase == PH_POLL && xfer_rx[ST_BUSY]) gap_val = GAP_W'(POLL_GAP);
        end else if (state == S_RDOUT && rd_ready && last) begin
            gap_load = 1'b1;
        end
    end

    nor_gap_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .value(gap_val), .expired(gap_exp)
    );

    // Request sequencing: frame stepping, byte streams and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_POLL;
            op_q    <= OP_READ;
            addr_q  <= '0;
            len_q   <= '0;
            half_q  <= 1'b0;
            idx     <= '0;
            wbuf    <= '0;
            rbuf    <= '0;
            st_busy <= 1'b0;
            st_fail <= 1'b0;
            err_acc <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q    <= op_e'(req_op);
                    addr_q  <= req_addr;
                    len_q   <= req_len;
                    half_q  <= 1'b0;
                    err_acc <= 1'b0;
                    phase   <= PH_POLL;
                    idx     <= '0;
                    state   <= S_XFER;
                end
                S_XFER: if (xfer_done) begin
                    if (phase == PH_POLL && idx == IDX_W'(1)) begin
                        st_busy <= xfer_rx[ST_BUSY];
                        st_fail <= xfer_rx[ST_FAIL];
                    end
                    if (is_data && op_q == OP_READ) begin
                        rbuf  <= xfer_rx;
                        state <= S_RDOUT;
                    end else if (last) begin
                        state <= S_GAP;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= (phase == PH_CMD && op_q == OP_BLKWR && idx >= IDX_W'(3))
                                 ? S_WAITWR : S_XFER;
                    end
                end
                S_WAITWR: if (wr_valid) begin
                    wbuf  <= wr_data;
                    state <= S_XFER;
                end
                S_RDOUT: if (rd_ready) begin
                    if (last) begin
                        state <= S_GAP;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= S_XFER;
                    end
                end
                S_GAP: if (gap_exp) begin
                    idx <= '0;
                    unique case (phase)
                        PH_POLL: begin
                            state <= S_XFER;
                            if (!st_busy) begin
                                err_acc <= err_acc | st_fail;
                                phase   <= (op_q == OP_READ) ? PH_CMD : PH_WREN;
                            end
                        end
                        PH_WREN: begin
                            phase <= PH_CMD;
                            state <= S_XFER;
                        end
                        default: begin
                            if (op_q == OP_BLKWR && !half_q) begin
                                half_q <= 1'b1;
                                phase  <= PH_POLL;
                                state  <= S_XFER;
                            end else begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                                err_q  <= err_acc;
                            end
                        end
                    endcase
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign cs_n      = !(state == S_XFER || state == S_WAITWR || state == S_RDOUT);
    assign xfer_req  = (state == S_XFER);
    assign xfer_tx   = tx;
    assign wr_ready  = (state == S_WAITWR);
    assign rd_valid  = (state == S_RDOUT);
    assign rd_data   = rbuf;
    assign done      = done_q;
    assign err       = err_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Protocol checker for nor_cmd_seq, attached by bind. Watches only ports.
// Assumes CS_GAP is small enough for an 8-bit saturating gap counter.
module nor_cmd_seq_chk #(
    parameter int CS_GAP = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       cs_n,
    input logic       xfer_req,
    input logic [7:0] xfer_tx,
    input logic       xfer_done
);
    logic [7:0] hi_cnt;
    logic       seen_frame;

    // Count consecutive deselected cycles; remember that a frame has occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (!cs_n)              hi_cnt <= '0;
            else if (hi_cnt != '1)  hi_cnt <= hi_cnt + 8'd1;
            if (!cs_n) seen_frame <= 1'b1;
        end
    end

    // R1: reset leaves the interface deselected and idle.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cs_n && req_ready && !done && !xfer_req));

    // R3: minimum deselect time between frames.
    a_r3_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_frame && $fell(cs_n)) |-> (hi_cnt >= 8'(CS_GAP + 1)));

    // R5: read byte held until the host takes it.
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R10: completion is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: ready only while nothing is on the bus.
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !xfer_req));

    // R11: transfers happen only inside a frame.
    a_r11_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !cs_n);

    // R11: a pending transfer keeps its byte.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done)
);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int LEN_W = 16;
    localparam int PAGE  = 256;
    localparam int CSG   = 1;
    localparam int PG    = 6;
    localparam int LAT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic done, err;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid, rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic cs_n, xfer_req;
    logic [7:0] xfer_tx;
    logic xfer_done = 1'b0;
    logic [7:0] xfer_rx = '0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE), .CS_GAP(CSG), .POLL_GAP(PG)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .done(done), .err(err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] a;
        logic        has_a;
        logic        use_fill;
        logic [31:0] ndata;
        logic [31:0] seed;
    } frm_t;

    int checks = 0;
    int fails = 0;
    frm_t expq[$];
    logic [7:0] stq[$];
    logic [7:0] rdq[$];
    logic [7:0] fr[$];
    logic [7:0] last_st = 8'h00;
    int wr_base = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rdpat(logic [23:0] a);
        return 8'(a * 7 + (a >> 8) + 3);
    endfunction

    function automatic logic [7:0] wrpat(int j);
        return 8'(j * 13 + 5);
    endfunction

    function automatic logic [7:0] exp_byte(frm_t e, int i);
        int hdr;
        hdr = e.has_a ? 4 : 1;
        if (i == 0) return e.op;
        if (e.has_a && i < 4) return e.a[8*(3-i) +: 8];
        if (e.use_fill) return 8'hA5;
        return wrpat(int'(e.seed) + i - hdr);
    endfunction

    // Flash response for the byte just shifted (status, array data, or idle).
    function automatic logic [7:0] flash_resp();
        int i;
        logic [7:0] s;
        i = fr.size() - 1;
        if (fr[0] == 8'h05 && i == 1) begin
            s = (stq.size() != 0) ? stq.pop_front() : 8'h00;
            last_st = s;
            return s;
        end
        if (fr[0] == 8'h03 && i >= 4) return rdpat({fr[1], fr[2], fr[3]} + 24'(i - 4));
        return 8'hFF;
    endfunction

    task automatic frame_end();
        frm_t e;
        int n;
        bit ok;
        int bad;
        if (expq.size() == 0) begin
            chk(0, "R2", "unexpected frame, first byte", 32'(fr[0]), 32'h0);
            return;
        end
        e = expq.pop_front();
        n = (e.has_a ? 4 : 1) + int'(e.ndata);
        ok = (fr.size() == n);
        bad = -1;
        for (int i = 0; i < fr.size() && i < n; i++)
            if (fr[i] !== exp_byte(e, i) && bad < 0) bad = i;
        if (bad >= 0) ok = 0;
        case (e.op)
            8'h05: chk(ok, "R2", "status frame", bad >= 0 ? 32'(fr[bad]) : 32'(fr.size()),
                       bad >= 0 ? 32'(exp_byte(e, bad)) : 32'(n));
            8'h06: chk(ok, "R4", "write-enable frame", 32'(fr.size()), 32'(n));
            8'h03: chk(ok, "R5", "read frame", bad >= 0 ? 32'(fr[bad]) : 32'(fr.size()),
                       bad >= 0 ? 32'(exp_byte(e, bad)) : 32'(n));
            8'h02: chk(ok, "R6", "page program frame", bad >= 0 ? 32'(fr[bad]) : 32'(fr.size()),
                       bad >= 0 ? 32'(exp_byte(e, bad)) : 32'(n));
            8'h20: chk(ok, "R7", "sector erase frame", bad >= 0 ? 32'(fr[bad]) : 32'(fr.size()),
                       bad >= 0 ? 32'(exp_byte(e, bad)) : 32'(n));
            default: chk(ok, "R8", "chip erase frame", bad >= 0 ? 32'(fr[bad]) : 32'(fr.size()),
                         bad >= 0 ? 32'(exp_byte(e, bad)) : 32'(n));
        endcase
    endtask

    // Per-clock model: SPI engine, flash, write/read streams, frame and gap checks.
    initial begin
        int cnt = 0;
        int hi = 0;
        int wr_idx = 0;
        int tick = 0;
        bit csp = 1'b1;
        bit lbusy = 1'b0;
        bit hs_w = 1'b0;
        forever begin
            @(negedge clk);
            tick++;
            if (!rst_n) continue;
            if (hs_w) wr_idx++;
            wr_valid = 1'b1;
            wr_data  = wrpat(wr_idx);
            hs_w     = wr_valid && wr_ready;
            rd_ready = (tick % 3) != 1;
            if (rd_valid && rd_ready) rdq.push_back(rd_data);
            if (xfer_req) chk(!cs_n, "R11", "transfer outside frame", 32'(cs_n), 32'h0);
            if (csp && !cs_n) begin
                fr.delete();
                if (lbusy) chk(hi >= PG + 1, "R3", "gap after busy poll", 32'(hi), 32'(PG + 1));
                else       chk(hi >= CSG + 1, "R3", "gap between frames", 32'(hi), 32'(CSG + 1));
                hi = 0;
            end
            if (cs_n) hi++;
            if (!csp && cs_n) begin
                lbusy = (fr.size() > 0 && fr[0] == 8'h05 && last_st[0]);
                frame_end();
            end
            csp = cs_n;
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_req) begin
                cnt++;
                if (cnt == LAT) begin
                    cnt = 0;
                    fr.push_back(xfer_tx);
                    xfer_rx   = flash_resp();
                    xfer_done = 1'b1;
                end
            end
        end
    end

    task automatic pf(input logic [7:0] op, input logic [23:0] a, input bit has_a,
                      input bit use_fill, input int nd, input int seed);
        frm_t e;
        e.op = op; e.a = a; e.has_a = has_a; e.use_fill = use_fill;
        e.ndata = 32'(nd); e.seed = 32'(seed);
        expq.push_back(e);
    endtask

    task automatic polls(input int nbusy, input logic [7:0] busy_st, input logic [7:0] fin);
        for (int k = 0; k < nbusy; k++) begin
            stq.push_back(busy_st);
            pf(8'h05, 24'h0, 0, 1, 1, 0);
        end
        stq.push_back(fin);
        pf(8'h05, 24'h0, 0, 1, 1, 0);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input int len,
                          input bit exp_err, input string rq);
        int n;
        rdq.delete();
        @(negedge clk);
        req_op = op; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10", "ready dropped after accept", 32'(req_ready), 32'h0);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (!done && req_ready) chk(0, "R10", "ready inside request", 32'h1, 32'h0);
        end
        chk(done, rq, "done seen", 32'(done), 32'h1);
        chk(err == exp_err, "R9", "error flag", 32'(err), 32'(exp_err));
        chk(req_ready, "R10", "ready with done", 32'(req_ready), 32'h1);
        chk(expq.size() == 0, rq, "frames left unsent", 32'(expq.size()), 32'h0);
        if (op == 2'd0) begin
            chk(rdq.size() == len, "R5", "read byte count", 32'(rdq.size()), 32'(len));
            for (int k = 0; k < rdq.size() && k < len; k++)
                chk(rdq[k] == rdpat(a + 24'(k)), "R5", "read data", 32'(rdq[k]),
                    32'(rdpat(a + 24'(k))));
        end
        @(negedge clk);
        chk(!done, "R10", "done one cycle", 32'(done), 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n && req_ready && !xfer_req && !done, "R1", "reset state",
            {28'h0, cs_n, req_ready, xfer_req, done}, 32'hC);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n && req_ready && !done, "R1", "idle after reset", {29'h0, cs_n, req_ready, done}, 32'h6);

        // R2/R3/R5: read with two busy polls whose fail bit must be ignored (R9).
        polls(2, 8'h21, 8'h00);
        pf(8'h03, 24'h012345, 1, 1, 5, 0);
        run_op(2'd0, 24'h012345, 5, 0, "R5");

        // R7/R4: sector erase of sector 0x0AB.
        polls(0, 8'h01, 8'h00);
        pf(8'h06, 24'h0, 0, 0, 0, 0);
        pf(8'h20, 24'h0AB000, 1, 0, 0, 0);
        run_op(2'd2, 24'h0000AB, 0, 0, "R7");

        // R8/R4: chip erase with one busy poll.
        polls(1, 8'h01, 8'h00);
        pf(8'h06, 24'h0, 0, 0, 0, 0);
        pf(8'hC7, 24'h0, 0, 0, 0, 0);
        run_op(2'd3, 24'h0, 0, 0, "R8");

        // R6: block 0x0102 -> pages 0x0204 and 0x0205.
        polls(0, 8'h01, 8'h00);
        pf(8'h06, 24'h0, 0, 0, 0, 0);
        pf(8'h02, 24'h020400, 1, 0, PAGE, wr_base);
        polls(1, 8'h01, 8'h00);
        pf(8'h06, 24'h0, 0, 0, 0, 0);
        pf(8'h02, 24'h020500, 1, 0, PAGE, wr_base + PAGE);
        run_op(2'd1, 24'h000102, 0, 0, "R6");
        wr_base += 2 * PAGE;

        // R9: not-busy status with the fail bit set.
        polls(1, 8'h01, 8'h20);
        pf(8'h03, 24'h000010, 1, 1, 2, 0);
        run_op(2'd0, 24'h000010, 2, 1, "R9");

        // R9/R5: flag cleared on the next request; read wraps at the top address.
        polls(0, 8'h01, 8'h00);
        pf(8'h03, 24'hFFFFFE, 1, 1, 3, 0);
        run_op(2'd0, 24'hFFFFFE, 3, 0, "R5");

        // R5: zero-length read sends only the header.
        polls(0, 8'h01, 8'h00);
        pf(8'h03, 24'h000100, 1, 1, 0, 0);
        run_op(2'd0, 24'h000100, 0, 0, "R5");

        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule